// File: doc/BRIEF.md
# Serial-Frame Power-Stage Command Selector

This block produces sixteen power-stage enable lines. Each line takes its on/off command from one of three places: its own parallel input pin, a 16-bit word received over a three-wire synchronous serial link, or a command word from a register written over SPI. The serial link has three lines: a frame clock, a data line and a sync strobe. On each rising edge of the frame clock, one data bit enters a shift register, first bit first. A rising edge on the sync strobe copies the shift register into a holding word, and that word drives the channels that are routed to the bus. The frame clock may stop for any length of time, because all state is kept in system-clock registers.

The SPI slave that owns the command word, the per-channel route mask and the path-select bit is outside this block; those values arrive as plain inputs. Every serial line and every parallel pin is synchronized to the system clock and passes a filter that ignores one-cycle pulses. Channel index 7 is special. It never listens to the bus, and it keeps working through a functional reset when it is routed to its pin and the logic supply is reported good.

Top module: `frame_out_ctrl`

## Requirements
- R1: A frame is 16 bits, sent first bit first. After 16 accepted rising edges of the frame clock, the bit sent n-th (n = 0..15) sits at word position n, and position n drives channel index n. Any 16-bit pattern is used as received, with no parity or correction.
- R2: The holding word changes only on an accepted rising edge of the sync strobe, and then takes the shift-register contents. Shifting a new frame without a sync strobe leaves the outputs unchanged.
- R3: When the frame clock stops mid-frame, the partial frame is kept. Toggling the data line while the frame clock is idle shifts nothing.
- R4: A level on the frame clock, data, sync or pin inputs is accepted only after two consecutive equal system-clock samples. A one-cycle pulse on the frame clock or the sync strobe has no effect.
- R5: When route-mask bit i is 1, enable i equals SPI command bit i.
- R6: When route-mask bit i is 0 and i is not 7, enable i follows the holding-word bit i when path-select is 0, and the filtered pin i when path-select is 1.
- R7: With route-mask bit 7 at 0, enable 7 follows filtered pin 7 for both values of path-select, and never follows the bus.
- R8: While rst_n is low, every enable except index 7 is 0, and the shift register and holding word are cleared. After release, the bus word reads 0 until a new frame is latched.
- R9: While rst_n is low, enable 7 follows filtered pin 7 if route-mask bit 7 is 0 and supply_ok is 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low; clears filters and all state |
| rst_n | input | 1 | Functional reset, active low; forces channels off |
| supply_ok | input | 1 | Logic supply good; lets channel 7 survive rst_n |
| frm_clk | input | 1 | Serial frame clock |
| frm_dat | input | 1 | Serial data line |
| frm_sync | input | 1 | Sync strobe; rising edge latches the frame |
| pin_in | input | 16 | Parallel command pins, one per channel |
| path_pin | input | 1 | Path select: 1 = parallel pins, 0 = serial bus word |
| spi_cmd | input | 16 | SPI command word |
| spi_route | input | 16 | Route mask: 1 = channel takes SPI command |
| en_out | output | 16 | Power-stage enables, 1 = on |

## Verification
The serial path is driven with frames 16'h1234, 16'hFFFF, 16'h5AA5 and 16'hC3A1. These patterns show whether the bit order or the channel mapping is wrong, and whether channel 7 leaks from the bus. One frame is split across a long stopped-clock gap while the data line toggles, which checks that the interface is static. One-cycle pulses on the frame clock and on the sync strobe are each followed by a check that would show a shift or a latch. A mixed route mask combines SPI and bus bits in a single output word. The reset checks sweep supply_ok and route bit 7 to separate the case where channel 7 is exempt from the cases where it is forced off.

// File: rtl/fctl_pkg.sv
package fctl_pkg;

  // command for one channel, before reset gating
  function automatic logic pick_cmd(input logic use_spi, input logic spi_bit,
                                    input logic pin_mode, input logic bus_bit,
                                    input logic pin_bit);
    if (use_spi) return spi_bit;
    return pin_mode ? pin_bit : bus_bit;
  endfunction

  // reset gating: channel runs when out of reset or when exempt
  function automatic logic gate_reset(input logic run, input logic keep,
                                      input logic cmd);
    return (run || keep) ? cmd : 1'b0;
  endfunction

endpackage

// File: rtl/glitch_filt.sv
module glitch_filt #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1, s2, hist;
  logic [W-1:0] agree;

  assign agree = s2 ~^ hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      hist <= '0;
      q    <= '0;
    end else begin
      s1   <= d;
      s2   <= s1;
      hist <= s2;
      q    <= (agree & s2) | (~agree & q);
    end
  end

  // an output bit may only move where the last two samples agreed
  AST_FILT_NEEDS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q ^ $past(q)) & ~$past(agree)) == '0); // R4

endmodule

// File: rtl/frame_rx.sv
module frame_rx #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fclk_f,
  input  logic         fdat_f,
  input  logic         fsync_f,
  output logic [W-1:0] word,
  output logic         shift_evt,
  output logic         latch_evt
);
  logic         fclk_q, fsync_q;
  logic [W-1:0] sr;

  assign shift_evt = fclk_f & ~fclk_q;
  assign latch_evt = fsync_f & ~fsync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fclk_q  <= 1'b0;
      fsync_q <= 1'b0;
      sr      <= '0;
      word    <= '0;
    end else begin
      fclk_q  <= fclk_f;
      fsync_q <= fsync_f;
      if (shift_evt) sr <= {fdat_f, sr[W-1:1]};
      if (latch_evt) word <= sr;
    end
  end

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> sr[W-1] == $past(fdat_f)); // R1
  AST_SR_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_evt |=> $stable(sr)); // R3
  AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> word == $past(sr)); // R2
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_evt |=> $stable(word)); // R2

endmodule

// File: rtl/src_select.sv
module src_select #(
  parameter int unsigned CH_N   = 16,
  parameter int unsigned SPEC_CH = 7
) (
  input  logic [CH_N-1:0] bus_word,
  input  logic [CH_N-1:0] pin_f,
  input  logic [CH_N-1:0] spi_cmd,
  input  logic [CH_N-1:0] spi_route,
  input  logic            path_pin,
  input  logic            run,
  input  logic            supply_ok,
  output logic [CH_N-1:0] en
);
  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    if (i == SPEC_CH) begin : g_spec
      logic keep;
      assign keep  = ~spi_route[i] & supply_ok;
      assign en[i] = fctl_pkg::gate_reset(run, keep,
                       fctl_pkg::pick_cmd(spi_route[i], spi_cmd[i], 1'b1,
                                          bus_word[i], pin_f[i]));
    end else begin : g_norm
      assign en[i] = fctl_pkg::gate_reset(run, 1'b0,
                       fctl_pkg::pick_cmd(spi_route[i], spi_cmd[i], path_pin,
                                          bus_word[i], pin_f[i]));
    end
  end
endmodule

// File: rtl/frame_out_ctrl.sv
module frame_out_ctrl #(
  parameter int unsigned CH_N    = 16,
  parameter int unsigned SPEC_CH = 7
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            rst_n,
  input  logic            supply_ok,
  input  logic            frm_clk,
  input  logic            frm_dat,
  input  logic            frm_sync,
  input  logic [CH_N-1:0] pin_in,
  input  logic            path_pin,
  input  logic [CH_N-1:0] spi_cmd,
  input  logic [CH_N-1:0] spi_route,
  output logic [CH_N-1:0] en_out
);
  localparam logic [CH_N-1:0] SPEC_MASK = CH_N'(1) << SPEC_CH;

  logic            frame_rst_n;
  logic [2:0]      ser_f;
  logic [CH_N-1:0] pin_f;
  logic [CH_N-1:0] bus_word;
  logic            shift_evt, latch_evt;

  assign frame_rst_n = por_n & rst_n;

  glitch_filt #(.W(3)) u_ser_filt (
    .clk(clk), .rst_n(por_n),
    .d({frm_sync, frm_dat, frm_clk}), .q(ser_f)
  );

  glitch_filt #(.W(CH_N)) u_pin_filt (
    .clk(clk), .rst_n(por_n), .d(pin_in), .q(pin_f)
  );

  frame_rx #(.W(CH_N)) u_rx (
    .clk(clk), .rst_n(frame_rst_n),
    .fclk_f(ser_f[0]), .fdat_f(ser_f[1]), .fsync_f(ser_f[2]),
    .word(bus_word), .shift_evt(shift_evt), .latch_evt(latch_evt)
  );

  src_select #(.CH_N(CH_N), .SPEC_CH(SPEC_CH)) u_sel (
    .bus_word(bus_word), .pin_f(pin_f), .spi_cmd(spi_cmd),
    .spi_route(spi_route), .path_pin(path_pin), .run(rst_n),
    .supply_ok(supply_ok), .en(en_out)
  );

  AST_RST_OFF: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |-> (en_out & ~SPEC_MASK) == '0); // R8
  AST_SPEC_KEEP: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n && !spi_route[SPEC_CH] && supply_ok) |-> en_out[SPEC_CH] == pin_f[SPEC_CH]); // R9
  AST_SPEC_OFF: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n && (spi_route[SPEC_CH] || !supply_ok)) |-> !en_out[SPEC_CH]); // R9
  AST_SPI_WINS: assert property (@(posedge clk) disable iff (!por_n)
    rst_n |-> ((en_out ^ spi_cmd) & spi_route) == '0); // R5
  AST_BUS_PATH: assert property (@(posedge clk) disable iff (!por_n)
    (rst_n && !path_pin) |-> ((en_out ^ bus_word) & ~spi_route & ~SPEC_MASK) == '0); // R6
  AST_SPEC_NO_BUS: assert property (@(posedge clk) disable iff (!por_n)
    (rst_n && !spi_route[SPEC_CH]) |-> en_out[SPEC_CH] == pin_f[SPEC_CH]); // R7

endmodule

// File: tb/frame_out_ctrl_bench.sv
module frame_out_ctrl_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic por_n = 1'b0, rst_n = 1'b0, supply_ok = 1'b1;
  logic frm_clk = 1'b0, frm_dat = 1'b0, frm_sync = 1'b0;
  logic [15:0] pin_in = '0, spi_cmd = '0, spi_route = 16'hFFFF;
  logic path_pin = 1'b0;
  logic [15:0] en_out;

  frame_out_ctrl u_frame_out_ctrl (.*);

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sbq[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [15:0] bw = '0, pend = '0;

  function automatic logic [15:0] model(input logic [15:0] w, p, s, m,
                                        input logic pm, run, sup);
    logic [15:0] r;
    for (int c = 0; c < 16; c++) begin
      logic v;
      if (m[c]) v = s[c];
      else if (c == 7 || pm) v = p[c];
      else v = w[c];
      if (!run && !(c == 7 && !m[c] && sup)) v = 1'b0;
      r[c] = v;
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (en_out !== it.exp) begin
        fails++;
        $display("FAIL %s: en_out=%h expected=%h", it.tag, en_out, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string tag);
    tick(6);
    sbq.push_back('{model(bw, pin_in, spi_cmd, spi_route, path_pin, rst_n, supply_ok), tag});
    tick(2);
  endtask

  task automatic send_bit(input logic b);
    frm_dat = b; tick(3);
    frm_clk = 1'b1; tick(3);
    frm_clk = 1'b0; tick(3);
  endtask

  task automatic send_frame(input logic [15:0] w);
    for (int i = 0; i < 16; i++) send_bit(w[i]);
    pend = w;
  endtask

  task automatic do_sync;
    frm_sync = 1'b1; tick(3);
    frm_sync = 1'b0; tick(3);
    bw = pend;
  endtask

  initial begin
    tick(3); por_n = 1'b1; tick(4);
    expect_now("R8 reset state all off");
    rst_n = 1'b1;
    spi_cmd = 16'hA5C3;
    expect_now("R5 all channels on SPI");
    spi_route = '0; path_pin = 1'b1; pin_in = 16'h3C96;
    expect_now("R6 parallel pin path");
    path_pin = 1'b0;
    send_frame(16'h1234);
    expect_now("R2 no change before sync");
    do_sync;
    expect_now("R1 R6 frame 1234 on bus, R7 ch7 from pin");
    pin_in[7] = 1'b0;
    send_frame(16'hFFFF); do_sync;
    expect_now("R7 ch7 ignores bus ones");
    send_frame(16'h5AA5); do_sync;
    expect_now("R1 frame 5AA5 no parity");
    // R3: stop frame clock mid-frame, wiggle data
    for (int i = 0; i < 8; i++) send_bit(16'hC3A1 >> i);
    for (int k = 0; k < 20; k++) begin frm_dat = ~frm_dat; tick(15); end
    for (int i = 8; i < 16; i++) send_bit(16'hC3A1 >> i);
    pend = 16'hC3A1; do_sync;
    expect_now("R3 split frame C3A1");
    // R4: one-cycle frame clock pulse with data high
    pend = 16'hC3A1;
    frm_dat = 1'b1; tick(3);
    frm_clk = 1'b1; tick(1); frm_clk = 1'b0; tick(4);
    do_sync;
    expect_now("R4 frame clock glitch ignored");
    // R4: one-cycle sync pulse after a new frame
    send_frame(16'h0F0F); pend = bw;
    frm_sync = 1'b1; tick(1); frm_sync = 1'b0; tick(4);
    expect_now("R4 sync glitch ignored");
    pend = 16'h0F0F; do_sync;
    expect_now("R2 proper sync latches 0F0F");
    spi_route = 16'h00FF; spi_cmd = 16'hF00F;
    expect_now("R5 mixed route SPI and bus");
    // reset handling
    spi_route = 16'h0000; pin_in = 16'h0080; supply_ok = 1'b1;
    rst_n = 1'b0;
    expect_now("R9 ch7 exempt from reset");
    supply_ok = 1'b0;
    expect_now("R9 ch7 off without supply");
    supply_ok = 1'b1; spi_route = 16'h0080; spi_cmd = 16'h0080;
    expect_now("R9 ch7 off when on SPI");
    spi_route = '0; pin_in = '0;
    rst_n = 1'b1; bw = '0; pend = '0;
    expect_now("R8 bus word cleared by reset");
    tick(4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule